// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block holds the register state behind the command decoder of a general-purpose I/O expander with 28 physical ports, numbered 4 to 31. Each cycle, the decoder presents at most one command: a 7-bit address, a write flag and a data byte. Writes take effect on the next clock edge. A read returns its byte one cycle later, together with a valid strobe.

Each port has a 2-bit mode field and an output latch. The modes are packed four to a mode register. The latches can be reached in two ways: one port at a time, or through an 8-port window that may start at any port number, with no alignment boundary. A global configuration register holds a run/shutdown bit and a detection-enable bit, and that bit is exported to the change-detection logic. From this state the block drives output enable, output value and pull-up enable for every pin.

Power handling is a two-state machine. PWR_SHDN is the reset state. PWR_RUN is normal operation. Transition GO_RUN happens when the configuration register is written with bit 0 = 1. Transition GO_SHDN happens when it is written with bit 0 = 0. In PWR_SHDN every pin is forced to an input with its pull-up off, but all stored registers are kept and can still be written.

Top module: `gpio_xp_regbank`

## Requirements
- R1: After reset, every mode register reads 0xAA, every output latch is 0, and the configuration register reads 0x00. The block starts in PWR_SHDN, with all output enables and pull-up enables at 0.
- R2: Address 0x20+n (n = 0..31) reaches port n alone through data bit 0, and bits 7:1 read as 0. For n = 0..3 a write changes nothing and a read returns 0.
- R3: Address 0x40+k (k = 0..31) reaches ports k..k+7, with data bit i mapped to port k+i. Bits that land on a port below 4 or above 31 are not written and read as 0.
- R4: Mode registers sit at 0x09..0x0F. Register 0x09+j holds ports 4+4j..7+4j as 2-bit fields, lowest port in bits 1:0. Each register reads back exactly as it was written.
- R5: In PWR_RUN, mode 01 enables the output driver and the pin drives the latch value. Mode 11 is an input with pull-up. Modes 10 and 00 are inputs without pull-up. Output value is 0 whenever the driver is off, and no pin ever has both driver and pull-up on.
- R6: A port read returns the output latch when the port is actively driving. Otherwise it returns the pin level.
- R7: The configuration register at 0x04 reads back as {bit7 = detect enable, bits 6:1 = 0, bit0 = run}, and the detect enable is exported on `detect_en`.
- R8: In PWR_SHDN all output enables and pull-ups are 0. Writes to latches and modes still take effect. GO_RUN restores the pin controls that the stored registers define, and a configuration write never alters stored port state.
- R9: Addresses outside 0x04, 0x09..0x0F, 0x20..0x5F read 0 and ignore writes. The detection mask address 0x06 also reads 0 here.
- R10: `rd_valid` pulses for one cycle exactly one cycle after each read command and never after a write. `rd_data` is 0 whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Write data |
| pin_in | input | 28 | Sampled pin levels, bit i = port i+4 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| pin_oe | output | 28 | Output driver enable per pin |
| pin_out | output | 28 | Driven level per pin |
| pin_pu | output | 28 | Pull-up enable per pin |
| detect_en | output | 1 | Change-detection enable bit |
| run_mode | output | 1 | 1 in PWR_RUN |

## Verification
The assertions check four things on every cycle: that no pin has driver and pull-up on together, that shutdown keeps every driver and pull-up off, that configuration writes and writes to ports 0 to 3 leave the latches and modes untouched, and the read-strobe timing and idle-zero data rule. Only the bench scenarios can show the address arithmetic. That covers window reads and writes that straddle the low and high port limits, the packing of mode fields, readback switching between latch and pin level, and the restore of the exact pin configuration after leaving shutdown.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_CFG    = 7'h04;
    localparam logic [ADDR_W-1:0] A_MODE0  = 7'h09;
    localparam logic [ADDR_W-1:0] A_SINGLE = 7'h20;
    localparam logic [ADDR_W-1:0] A_WIN    = 7'h40;

    typedef enum logic [1:0] {
        PM_RSVD  = 2'b00,
        PM_OUT   = 2'b01,
        PM_IN    = 2'b10,
        PM_IN_PU = 2'b11
    } pin_mode_e;

    typedef enum logic {
        PWR_SHDN = 1'b0,
        PWR_RUN  = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/gpio_xp_win_dec.sv
module gpio_xp_win_dec
    import gpio_xp_pkg::*;
#(
    parameter int FIRST_PORT = 4,
    parameter int PORT_SPACE = 32,
    parameter int WIN        = 8,
    localparam int NP        = PORT_SPACE - FIRST_PORT,
    localparam int WIDX      = $clog2(WIN)
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIN-1:0]    wdata,
    output logic [NP-1:0]     lat_we,
    output logic [NP-1:0]     lat_wd
);
    for (genvar g = 0; g < NP; g++) begin : g_port
        localparam int P = g + FIRST_PORT;
        logic we_l, wd_l;
        int   a, off;
        always_comb begin
            a    = int'(addr);
            off  = 0;
            we_l = 1'b0;
            wd_l = 1'b0;
            if (wr) begin
                if (a == int'(A_SINGLE) + P) begin
                    we_l = 1'b1;
                    wd_l = wdata[0];
                end else if (a >= int'(A_WIN) && a < int'(A_WIN) + PORT_SPACE) begin
                    off = P - (a - int'(A_WIN));
                    if (off >= 0 && off < WIN) begin
                        we_l = 1'b1;
                        wd_l = wdata[WIDX'(off)];
                    end
                end
            end
        end
        assign lat_we[g] = we_l;
        assign lat_wd[g] = wd_l;
    end
endmodule

// File: rtl/gpio_xp_pin_ctrl.sv
module gpio_xp_pin_ctrl
    import gpio_xp_pkg::*;
#(
    parameter int NP = 28
) (
    input  logic            run,
    input  logic [2*NP-1:0] mode_q,
    input  logic [NP-1:0]   lat_q,
    input  logic [NP-1:0]   pin_in,
    output logic [NP-1:0]   oe,
    output logic [NP-1:0]   out,
    output logic [NP-1:0]   pu,
    output logic [NP-1:0]   rb
);
    for (genvar g = 0; g < NP; g++) begin : g_pin
        pin_mode_e m;
        logic drv, pull;
        assign m = pin_mode_e'(mode_q[2*g +: 2]);
        always_comb begin
            drv  = 1'b0;
            pull = 1'b0;
            unique case (m)
                PM_OUT:   drv  = run;
                PM_IN_PU: pull = run;
                PM_IN,
                PM_RSVD:  ;
            endcase
        end
        assign oe[g]  = drv;
        assign pu[g]  = pull;
        assign out[g] = drv & lat_q[g];
        assign rb[g]  = drv ? lat_q[g] : pin_in[g];
    end
endmodule

// File: rtl/gpio_xp_rd_mux.sv
module gpio_xp_rd_mux
    import gpio_xp_pkg::*;
#(
    parameter int FIRST_PORT = 4,
    parameter int PORT_SPACE = 32,
    parameter int WIN        = 8,
    localparam int NP        = PORT_SPACE - FIRST_PORT,
    localparam int NMODE     = NP / 4,
    localparam int IDX_W     = $clog2(NP)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NP-1:0]     rb,
    input  logic [2*NP-1:0]   mode_q,
    input  logic              det,
    input  logic              run,
    output logic [WIN-1:0]    rdata
);
    int a, p;
    always_comb begin
        a     = int'(addr);
        p     = 0;
        rdata = '0;
        if (a == int'(A_CFG)) begin
            rdata[WIN-1] = det;
            rdata[0]     = run;
        end else if (a >= int'(A_MODE0) && a < int'(A_MODE0) + NMODE) begin
            for (int j = 0; j < NMODE; j++) begin
                if (a == int'(A_MODE0) + j) rdata = mode_q[j*8 +: 8];
            end
        end else if (a >= int'(A_SINGLE) && a < int'(A_SINGLE) + PORT_SPACE) begin
            p = a - int'(A_SINGLE);
            if (p >= FIRST_PORT) rdata[0] = rb[IDX_W'(p - FIRST_PORT)];
        end else if (a >= int'(A_WIN) && a < int'(A_WIN) + PORT_SPACE) begin
            for (int i = 0; i < WIN; i++) begin
                p = a - int'(A_WIN) + i;
                if (p >= FIRST_PORT && p < PORT_SPACE)
                    rdata[i] = rb[IDX_W'(p - FIRST_PORT)];
            end
        end
    end
endmodule

// File: rtl/gpio_xp_regbank.sv
module gpio_xp_regbank
    import gpio_xp_pkg::*;
#(
    parameter int FIRST_PORT = 4,
    parameter int PORT_SPACE = 32,
    parameter int WIN        = 8,
    localparam int NP        = PORT_SPACE - FIRST_PORT,
    localparam int NMODE     = NP / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WIN-1:0]    cmd_wdata,
    input  logic [NP-1:0]     pin_in,
    output logic              rd_valid,
    output logic [WIN-1:0]    rd_data,
    output logic [NP-1:0]     pin_oe,
    output logic [NP-1:0]     pin_out,
    output logic [NP-1:0]     pin_pu,
    output logic              detect_en,
    output logic              run_mode
);
    pwr_state_e        state_q, state_d;
    logic [2*NP-1:0]   mode_q, mode_d;
    logic [NP-1:0]     lat_q, lat_d;
    logic              det_q, det_d;
    logic [NP-1:0]     lat_we, lat_wd, rb;
    logic [WIN-1:0]    rmux;
    logic              wr, rd, cfg_wr;

    assign wr     = cmd_valid && cmd_write;
    assign rd     = cmd_valid && !cmd_write;
    assign cfg_wr = wr && (cmd_addr == A_CFG);

    // power state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_SHDN;
        else        state_q <= state_d;
    end

    // transitions GO_RUN / GO_SHDN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_SHDN: if (cfg_wr && cmd_wdata[0])  state_d = PWR_RUN;
            PWR_RUN:  if (cfg_wr && !cmd_wdata[0]) state_d = PWR_SHDN;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state_q)
            PWR_SHDN: run_mode = 1'b0;
            PWR_RUN:  run_mode = 1'b1;
        endcase
    end

    always_comb begin
        det_d  = cfg_wr ? cmd_wdata[WIN-1] : det_q;
        mode_d = mode_q;
        if (wr) begin
            for (int j = 0; j < NMODE; j++) begin
                if (int'(cmd_addr) == int'(A_MODE0) + j) mode_d[j*8 +: 8] = cmd_wdata;
            end
        end
        lat_d = (lat_q & ~lat_we) | (lat_wd & lat_we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= {NP{2'b10}};
            lat_q    <= '0;
            det_q    <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            mode_q   <= mode_d;
            lat_q    <= lat_d;
            det_q    <= det_d;
            rd_valid <= rd;
            rd_data  <= rd ? rmux : '0;
        end
    end

    assign detect_en = det_q;

    gpio_xp_win_dec #(.FIRST_PORT(FIRST_PORT), .PORT_SPACE(PORT_SPACE), .WIN(WIN)) u_dec (
        .wr(wr), .addr(cmd_addr), .wdata(cmd_wdata), .lat_we(lat_we), .lat_wd(lat_wd)
    );

    gpio_xp_pin_ctrl #(.NP(NP)) u_pins (
        .run(run_mode), .mode_q(mode_q), .lat_q(lat_q), .pin_in(pin_in),
        .oe(pin_oe), .out(pin_out), .pu(pin_pu), .rb(rb)
    );

    gpio_xp_rd_mux #(.FIRST_PORT(FIRST_PORT), .PORT_SPACE(PORT_SPACE), .WIN(WIN)) u_rmux (
        .addr(cmd_addr), .rb(rb), .mode_q(mode_q), .det(det_q), .run(run_mode), .rdata(rmux)
    );

    AST_OE_PU_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_pu) == '0); // R5
    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |-> (pin_oe == '0 && pin_pu == '0)); // R8
    AST_CFG_KEEPS_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ($stable(mode_q) && $stable(lat_q))); // R8
    AST_LOW_PORT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cmd_addr >= A_SINGLE && cmd_addr < A_SINGLE + 7'(FIRST_PORT)) |=> $stable(lat_q)); // R2
    AST_RD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && !cmd_write)); // R10
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0); // R10
endmodule

// File: tb/tb_gpio_xp_regbank.sv
module tb_gpio_xp_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic [NP-1:0] pin_in = '0;
    logic rd_valid, detect_en, run_mode;
    logic [7:0] rd_data;
    logic [NP-1:0] pin_oe, pin_out, pin_pu;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_xp_regbank dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .pin_in(pin_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .pin_oe(pin_oe), .pin_out(pin_out),
        .pin_pu(pin_pu), .detect_en(detect_en), .run_mode(run_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = 1'b0;
        check("R10 no strobe after write", 32'(rd_valid), 32'd0);
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a; cmd_wdata = 8'h5A;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pins(input string tag, input logic [NP-1:0] oe, input logic [NP-1:0] pu,
                        input logic [NP-1:0] o);
        check({tag, " oe"}, 32'(pin_oe), 32'(oe));
        check({tag, " pu"}, 32'(pin_pu), 32'(pu));
        check({tag, " out"}, 32'(pin_out), 32'(o));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 unexpected strobe actual=0x%0h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), 32'(rd_data), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pins("R1 reset", '0, '0, '0);
        check("R1 run_mode", 32'(run_mode), 32'd0);
        rd(7'h09, 8'hAA, "R1 mode reg 0x09");
        rd(7'h0F, 8'hAA, "R1 mode reg 0x0F");
        rd(7'h04, 8'h00, "R1 config");
        rd(7'h3F, 8'h00, "R1 latch port31");

        wr(7'h04, 8'h01);
        wr(7'h09, 8'h55);
        wr(7'h0A, 8'hCD);
        pins("R5 modes", 28'h000001F, 28'h00000A0, '0);
        rd(7'h0A, 8'hCD, "R4 mode reg 0x0A");
        rd(7'h09, 8'h55, "R4 mode reg 0x09");

        wr(7'h25, 8'hFF);
        check("R5 port5 drives", 32'(pin_out), 32'h2);
        rd(7'h25, 8'h01, "R2 R6 single port5");
        wr(7'h22, 8'h01);
        rd(7'h22, 8'h00, "R2 port2 absent");
        rd(7'h24, 8'h00, "R2 port4 latch");

        wr(7'h42, 8'hFF);
        check("R3 window write pins", 32'(pin_out), 32'h1F);
        rd(7'h42, 8'h7C, "R3 window k=2");
        wr(7'h5C, 8'h00);
        pin_in = 28'hA000000;
        rd(7'h5C, 8'h0A, "R3 window k=28 top");
        pin_in = '0;
        rd(7'h40, 8'hF0, "R3 window k=0");

        pin_in[8] = 1'b1;
        rd(7'h2C, 8'h01, "R6 input port12 level");
        pin_in = '0;

        wr(7'h04, 8'hC0);
        pins("R8 shutdown", '0, '0, '0);
        check("R7 detect_en", 32'(detect_en), 32'd1);
        rd(7'h04, 8'h80, "R7 config bit6 reads 0");
        rd(7'h25, 8'h00, "R8 shutdown pin level low");
        pin_in[1] = 1'b1;
        rd(7'h25, 8'h01, "R8 shutdown pin level high");
        pin_in = '0;
        wr(7'h26, 8'h00);
        rd(7'h09, 8'h55, "R8 modes kept");
        wr(7'h04, 8'h81);
        pins("R8 restore", 28'h000001F, 28'h00000A0, 28'h000001B);
        rd(7'h04, 8'h81, "R7 config readback");
        rd(7'h26, 8'h00, "R8 write in shutdown kept");

        wr(7'h10, 8'hFF);
        wr(7'h06, 8'hFF);
        wr(7'h60, 8'hFF);
        pins("R9 unmapped writes", 28'h000001F, 28'h00000A0, 28'h000001B);
        rd(7'h10, 8'h00, "R9 read 0x10");
        rd(7'h06, 8'h00, "R9 read 0x06");
        rd(7'h60, 8'h00, "R9 read 0x60");
        rd(7'h0A, 8'hCD, "R9 modes untouched");

        repeat (3) @(negedge clk);
        check("R10 all reads answered", 32'(exp_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule